// File: doc/BRIEF.md
# Expansion Cartridge Window Decoder

This block sits between a host bus and a 1 MiB expansion cartridge. Every host access has the window base subtracted from its address, and the result is wrapped to the window size. Address bits [19:16] of the resulting offset then steer the access to one of four places:

- a single I/O status word,
- a 32-entry word register file that fronts an audio decoder,
- a placeholder register window for a video decoder,
- a shared ROM/RAM memory port.

The lower quarter of the window is boot ROM, which is readable but cannot be written. The upper half is RAM. The gap between them reads as zero.

The host talks to the block through a request/acknowledge port. Byte, word and long sizes are supported. A long access runs as two word accesses, and the high half goes first.

Each byte or word access takes one issue cycle and one capture cycle. The block then gives a single-cycle acknowledge. The memory behind the memory port is external and returns read data in the cycle after it is enabled.

The block holds the I/O word itself. It also holds the audio register file, including separate interrupt mask and interrupt status storage that share two register indices.

Top module: `cart_window_decoder`

## Requirements
- R1: The window offset is (host_addr − WIN_BASE) taken modulo 2^WIN_AW. With the defaults, 0x300010 aliases 0x200010 and 0x1FFFFE maps to offset 0xFFFFE.
- R2: Offset bits [19:16] select the target: 0x4 is the I/O word, 0x5 is the audio registers, 0x7 is the video window, and every other value goes to the memory port.
- R3: Memory-path reads at offsets 0x00000–0x3FFFF and 0x80000–0xFFFFF return memory data, big-endian. mem_addr is offset[19:1]. A byte at an even offset is mem_rdata[15:8], and a byte at an odd offset is mem_rdata[7:0].
- R4: A memory-path read at an offset in 0x40000–0x7FFFF returns zero without asserting mem_en.
- R5: A memory-path write is issued (mem_we) only at offsets ≥ 0x80000; lower offsets drop it. A word write sets mem_be=2'b11. A byte write sets mem_be[1] for an even offset and mem_be[0] for an odd offset, and drives the byte on both lanes.
- R6: A long access (host_size=2) is performed as a word access at the offset, carrying bits [31:16], followed by a word access at offset+2, carrying bits [15:0].
- R7: The I/O bank has one word register at bank offset 0. Word accesses to any other offset read zero and are ignored. Byte accesses to the bank read zero and change nothing.
- R8: I/O word bits [13:0] read back the last value written there. Bit 14 reads 1 when any audio status bit has its mask bit set. Bit 15 reads the vid_irq input.
- R9: The audio bank holds 32 word registers indexed by offset bits [5:1]. Every index except 4 and 5 is plain read/write storage.
- R10: Word writes to audio index 4 or 5 set interrupt mask A or B. Word reads of index 4 or 5 return interrupt status A or B. Each status bit is set by the matching aud_evt_a or aud_evt_b bit and stays set until reset.
- R11: Byte accesses to the audio bank and all accesses to the video bank read zero and have no effect.
- R12: host_ack is a one-cycle pulse. It is seen 3 clock edges after the request is sampled for byte and word accesses, and 5 edges after for long accesses. Synchronous reset clears the I/O word, the audio registers, the masks and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 word, 2 long (3 acts as word) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Write data (byte in [7:0], word in [15:0]) |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | WIN_AW-1 | Memory word address |
| mem_be | output | 2 | Byte enables, [1] = even byte |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_en |
| aud_evt_a | input | 16 | Audio status A set pulses |
| aud_evt_b | input | 16 | Audio status B set pulses |
| vid_irq | input | 1 | Video decoder interrupt level |

## Verification
The bench builds the block with its defaults: a 32-bit host address, WIN_BASE 0x200000, a 20-bit window and 32 audio registers. Because the host address is wider than the window, addresses above and below the window are reachable, so the wrap of R1 can be shown as aliasing in both directions. With the default ROM end and RAM base, all three memory-path regions (ROM, gap and RAM) sit in distinct banks, and every bank code of R2 can be hit. The bench's memory model returns an address-derived pattern for words never written, so ROM reads and dropped writes can be told apart.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    localparam int BANK_W = 4;
    localparam int HALF_W = 16;

    localparam logic [BANK_W-1:0] BANK_IO  = 4'h4;
    localparam logic [BANK_W-1:0] BANK_AUD = 4'h5;
    localparam logic [BANK_W-1:0] BANK_VID = 4'h7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_MEM = 2'd0,
        TGT_IO  = 2'd1,
        TGT_AUD = 2'd2,
        TGT_VID = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/cwd_bank_decode.sv
module cwd_bank_decode
    import cwd_pkg::*;
#(
    parameter int WIN_AW   = 20,
    parameter int ROM_END  = 'h40000,
    parameter int RAM_BASE = 'h80000
) (
    input  logic [WIN_AW-1:0] off,
    output target_e           tgt,
    output logic              rd_ok,
    output logic              wr_ok
);
    localparam logic [WIN_AW-1:0] ROM_END_V  = WIN_AW'(ROM_END);
    localparam logic [WIN_AW-1:0] RAM_BASE_V = WIN_AW'(RAM_BASE);

    logic [BANK_W-1:0] bank;
    assign bank = off[WIN_AW-1 -: BANK_W];

    // R2: bank code picks the target
    always_comb begin
        case (bank)
            BANK_IO:  tgt = TGT_IO;
            BANK_AUD: tgt = TGT_AUD;
            BANK_VID: tgt = TGT_VID;
            default:  tgt = TGT_MEM;
        endcase
    end

    // R3/R4: readable outside the gap; R5: writable only in RAM
    assign rd_ok = (off < ROM_END_V) || (off >= RAM_BASE_V);
    assign wr_ok = (off >= RAM_BASE_V);
endmodule

// File: rtl/cwd_io_word.sv
module cwd_io_word
    import cwd_pkg::*;
#(
    parameter int FLAG_LO = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access,
    input  logic              we,
    input  logic              word,
    input  logic              at_reg,
    input  logic [HALF_W-1:0] wdata,
    input  logic              aud_pend,
    input  logic              vid_irq,
    output logic [HALF_W-1:0] rdata
);
    typedef struct packed {
        logic [FLAG_LO-1:0] store;
    } io_t;

    io_t s_d, s_q;
    logic hit;

    assign hit = word && at_reg;

    always_comb begin
        s_d = s_q;
        if (access && we && hit) begin
            s_d.store = wdata[FLAG_LO-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R8: two flag bits over the stored low bits
    always_comb begin
        if (hit) rdata = {vid_irq, aud_pend, s_q.store};
        else     rdata = '0;
    end

    p_io_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (access && we && !(word && at_reg)) |=> $stable(s_q.store));

    p_io_store_r8: assert property (@(posedge clk) disable iff (rst)
        (access && we && word && at_reg) |=> (s_q.store == $past(wdata[FLAG_LO-1:0])));
endmodule

// File: rtl/cwd_audio_regs.sv
module cwd_audio_regs
    import cwd_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int MASK_A  = 4,
    parameter int MASK_B  = 5,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access,
    input  logic              we,
    input  logic              word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] evt_a,
    input  logic [HALF_W-1:0] evt_b,
    output logic [HALF_W-1:0] rdata,
    output logic              pending
);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(MASK_A);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(MASK_B);

    typedef struct packed {
        logic [NREG-1:0][HALF_W-1:0] regs;
        logic [HALF_W-1:0]           mask_a;
        logic [HALF_W-1:0]           mask_b;
        logic [HALF_W-1:0]           stat_a;
        logic [HALF_W-1:0]           stat_b;
    } aud_t;

    aud_t s_d, s_q;
    logic wr;

    assign wr = access && we && word;

    always_comb begin
        s_d = s_q;
        // R10: sticky status bits
        s_d.stat_a = s_q.stat_a | evt_a;
        s_d.stat_b = s_q.stat_b | evt_b;
        if (wr) begin
            if (idx == IDX_A)      s_d.mask_a = wdata;
            else if (idx == IDX_B) s_d.mask_b = wdata;
            else                   s_d.regs[idx] = wdata;   // R9
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        if (!word)             rdata = '0;   // R11
        else if (idx == IDX_A) rdata = s_q.stat_a;
        else if (idx == IDX_B) rdata = s_q.stat_b;
        else                   rdata = s_q.regs[idx];
    end

    assign pending = |(s_q.stat_a & s_q.mask_a) || |(s_q.stat_b & s_q.mask_b);

    p_mask_a_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_A) |=> (s_q.mask_a == $past(wdata)));

    p_status_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((s_q.stat_a & $past(s_q.stat_a)) == $past(s_q.stat_a)));

    p_byte_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        (access && we && !word) |=> ($stable(s_q.regs) && $stable(s_q.mask_a)
                                     && $stable(s_q.mask_b)));
endmodule

// File: rtl/cart_window_decoder.sv
module cart_window_decoder
    import cwd_pkg::*;
#(
    parameter int                 ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 'h200000,
    parameter int                 WIN_AW   = 20,
    parameter int                 ROM_END  = 'h40000,
    parameter int                 RAM_BASE = 'h80000,
    parameter int                 AUD_REGS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WIN_AW-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic [15:0]       aud_evt_a,
    input  logic [15:0]       aud_evt_b,
    input  logic              vid_irq
);
    localparam int AUD_IDX_W  = $clog2(AUD_REGS);
    localparam int BANK_OFF_W = WIN_AW - BANK_W;
    localparam logic [WIN_AW-2:0] RAM_WADDR = (WIN_AW-1)'(RAM_BASE >> 1);
    localparam logic [WIN_AW-2:0] GAP_WLO   = (WIN_AW-1)'(ROM_END >> 1);

    typedef struct packed {
        seq_state_e        st;
        logic              phase;
        logic              we;
        acc_size_e         sz;
        logic [WIN_AW-1:0] off;
        logic [31:0]       wdata;
        logic [31:0]       rdata;
        target_e           tgt;
        logic              lane;
        logic              rd_ok;
        logic [HALF_W-1:0] regval;
    } seq_t;

    seq_t s_d, s_q;

    // R1: relative offset, wrapped to the window
    logic [ADDR_W-1:0] rel;
    logic [WIN_AW-1:0] host_off;
    logic              unused_hi_bits;
    assign rel            = host_addr - WIN_BASE;
    assign host_off       = rel[WIN_AW-1:0];
    assign unused_hi_bits = ^rel[ADDR_W-1:WIN_AW];

    logic [WIN_AW-1:0] sub_off;
    assign sub_off = s_q.off + (s_q.phase ? WIN_AW'(2) : WIN_AW'(0));

    target_e dec_tgt;
    logic    dec_rd_ok, dec_wr_ok;

    cwd_bank_decode #(
        .WIN_AW   (WIN_AW),
        .ROM_END  (ROM_END),
        .RAM_BASE (RAM_BASE)
    ) u_decode (
        .off   (sub_off),
        .tgt   (dec_tgt),
        .rd_ok (dec_rd_ok),
        .wr_ok (dec_wr_ok)
    );

    logic              issuing, is_word;
    logic [HALF_W-1:0] wr_half;

    assign issuing = (s_q.st == ST_ISSUE);
    assign is_word = (s_q.sz != SZ_BYTE);

    // R6: long supplies the high half first
    always_comb begin
        case (s_q.sz)
            SZ_LONG: wr_half = s_q.phase ? s_q.wdata[15:0] : s_q.wdata[31:16];
            SZ_WORD: wr_half = s_q.wdata[15:0];
            default: wr_half = {2{s_q.wdata[7:0]}};
        endcase
    end

    logic [HALF_W-1:0] io_rd, aud_rd;
    logic              aud_pend;

    cwd_io_word u_io (
        .clk      (clk),
        .rst      (rst),
        .access   (issuing && dec_tgt == TGT_IO),
        .we       (s_q.we),
        .word     (is_word),
        .at_reg   (sub_off[BANK_OFF_W-1:0] == '0),
        .wdata    (wr_half),
        .aud_pend (aud_pend),
        .vid_irq  (vid_irq),
        .rdata    (io_rd)
    );

    cwd_audio_regs #(
        .NREG (AUD_REGS)
    ) u_audio (
        .clk     (clk),
        .rst     (rst),
        .access  (issuing && dec_tgt == TGT_AUD),
        .we      (s_q.we),
        .word    (is_word),
        .idx     (sub_off[AUD_IDX_W:1]),
        .wdata   (wr_half),
        .evt_a   (aud_evt_a),
        .evt_b   (aud_evt_b),
        .rdata   (aud_rd),
        .pending (aud_pend)
    );

    logic [HALF_W-1:0] reg_rd;
    always_comb begin
        case (dec_tgt)
            TGT_IO:  reg_rd = io_rd;
            TGT_AUD: reg_rd = aud_rd;
            default: reg_rd = '0;      // R11: video window reads zero
        endcase
    end

    // R3: big-endian byte lane
    logic [HALF_W-1:0] mem_val, cap_val;
    always_comb begin
        if (is_word)     mem_val = mem_rdata;
        else if (s_q.lane) mem_val = {8'h00, mem_rdata[7:0]};
        else             mem_val = {8'h00, mem_rdata[15:8]};
    end

    always_comb begin
        if (s_q.tgt == TGT_MEM) cap_val = s_q.rd_ok ? mem_val : '0;   // R4
        else                    cap_val = s_q.regval;
    end

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    s_d.st    = ST_ISSUE;
                    s_d.phase = 1'b0;
                    s_d.we    = host_we;
                    s_d.sz    = (host_size == 2'd2) ? SZ_LONG :
                                (host_size == 2'd0) ? SZ_BYTE : SZ_WORD;
                    s_d.off   = host_off;
                    s_d.wdata = host_wdata;
                    s_d.rdata = '0;
                end
            end
            ST_ISSUE: begin
                s_d.tgt    = dec_tgt;
                s_d.lane   = sub_off[0];
                s_d.rd_ok  = dec_rd_ok;
                s_d.regval = reg_rd;
                s_d.st     = ST_WAIT;
            end
            ST_WAIT: begin
                if (!s_q.we) begin
                    case (s_q.sz)
                        SZ_LONG: begin
                            if (s_q.phase) s_d.rdata[15:0]  = cap_val;
                            else           s_d.rdata[31:16] = cap_val;
                        end
                        SZ_WORD: s_d.rdata = {16'h0000, cap_val};
                        default: s_d.rdata = {24'h000000, cap_val[7:0]};
                    endcase
                end
                if (s_q.sz == SZ_LONG && !s_q.phase) begin
                    s_d.phase = 1'b1;
                    s_d.st    = ST_ISSUE;
                end else begin
                    s_d.st = ST_ACK;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R5: memory port drive
    assign mem_en    = issuing && dec_tgt == TGT_MEM && (s_q.we ? dec_wr_ok : dec_rd_ok);
    assign mem_we    = issuing && dec_tgt == TGT_MEM && s_q.we && dec_wr_ok;
    assign mem_addr  = sub_off[WIN_AW-1:1];
    assign mem_be    = is_word ? 2'b11 : (sub_off[0] ? 2'b01 : 2'b10);
    assign mem_wdata = wr_half;

    assign host_ack   = (s_q.st == ST_ACK);
    assign host_rdata = s_q.rdata;

    p_ack_single_r12: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    p_accept_r12: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_IDLE && host_req) |=> (s_q.st == ST_ISSUE && !s_q.phase));

    p_mem_write_ram_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && mem_addr >= RAM_WADDR));

    p_gap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> !(mem_addr >= GAP_WLO && mem_addr < RAM_WADDR));

    p_long_hi_first_r6: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_WAIT && s_q.sz == SZ_LONG && !s_q.phase)
            |=> (s_q.st == ST_ISSUE && s_q.phase));
endmodule

// File: tb/cart_window_decoder_tb.sv
module cart_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_size = 2'd1;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        mem_en, mem_we;
    logic [18:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] aud_evt_a = '0, aud_evt_b = '0;
    logic        vid_irq = 1'b0;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    cart_window_decoder u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .aud_evt_a(aud_evt_a),
        .aud_evt_b(aud_evt_b), .vid_irq(vid_irq)
    );

    // memory model: unwritten words read (word address ^ 16'hA5C3)
    logic [15:0] mem_m [int];
    int          wr_cnt = 0;
    int          prev_a = 0, last_a = 0;
    logic [15:0] prev_d = '0, last_d = '0;

    function automatic logic [15:0] mem_rd(int a);
        if (mem_m.exists(a)) return mem_m[a];
        return 16'(a) ^ 16'hA5C3;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                logic [15:0] cur;
                cur = mem_rd(int'(mem_addr));
                if (mem_be[1]) cur[15:8] = mem_wdata[15:8];
                if (mem_be[0]) cur[7:0]  = mem_wdata[7:0];
                mem_m[int'(mem_addr)] = cur;
                wr_cnt = wr_cnt + 1;
                prev_a = last_a; prev_d = last_d;
                last_a = int'(mem_addr); last_d = mem_wdata;
            end
            mem_rdata <= mem_rd(int'(mem_addr));
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_size = sz; host_addr = a; host_wdata = wd;
        cyc = 0;
        rd = '0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            cyc++;
            if (host_ack) begin
                rd = host_rdata;
                break;
            end
        end
        host_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd1, 32'h240000, 32'h1234, 32'h0,    8'd7},   // R7 write reg
        '{1'b0, 2'd1, 32'h240000, 32'h0,    32'h1234, 8'd7},   // R7
        '{1'b1, 2'd1, 32'h240002, 32'hBEEF, 32'h0,    8'd7},   // R7 other offset
        '{1'b0, 2'd1, 32'h240002, 32'h0,    32'h0,    8'd7},   // R7
        '{1'b0, 2'd1, 32'h240000, 32'h0,    32'h1234, 8'd7},   // R7
        '{1'b1, 2'd0, 32'h240000, 32'h99,   32'h0,    8'd7},   // R7 byte
        '{1'b0, 2'd0, 32'h240000, 32'h0,    32'h0,    8'd7},   // R7
        '{1'b0, 2'd1, 32'h240000, 32'h0,    32'h1234, 8'd7},   // R7
        '{1'b1, 2'd1, 32'h240000, 32'hFFFF, 32'h0,    8'd8},   // R8
        '{1'b0, 2'd1, 32'h240000, 32'h0,    32'h3FFF, 8'd8},   // R8 flags not stored
        '{1'b1, 2'd1, 32'h240000, 32'h1234, 32'h0,    8'd8},   // R8
        '{1'b1, 2'd1, 32'h250006, 32'hCAFE, 32'h0,    8'd9},   // R9
        '{1'b0, 2'd1, 32'h250006, 32'h0,    32'hCAFE, 8'd9},   // R9
        '{1'b1, 2'd1, 32'h25003E, 32'h0101, 32'h0,    8'd9},   // R9 last index
        '{1'b0, 2'd1, 32'h25003E, 32'h0,    32'h0101, 8'd9},   // R9
        '{1'b1, 2'd1, 32'h250008, 32'h00FF, 32'h0,    8'd10},  // R10 mask A
        '{1'b0, 2'd1, 32'h250008, 32'h0,    32'h0,    8'd10},  // R10 status A
        '{1'b1, 2'd1, 32'h270010, 32'h5555, 32'h0,    8'd11},  // R11 video
        '{1'b0, 2'd1, 32'h270010, 32'h0,    32'h0,    8'd11},  // R11
        '{1'b0, 2'd0, 32'h250006, 32'h0,    32'h0,    8'd11},  // R11 audio byte read
        '{1'b1, 2'd0, 32'h250007, 32'h11,   32'h0,    8'd11},  // R11 audio byte write
        '{1'b0, 2'd1, 32'h250006, 32'h0,    32'hCAFE, 8'd11},  // R11
        '{1'b1, 2'd1, 32'h280100, 32'hA1B2, 32'h0,    8'd5},   // R5 RAM write
        '{1'b0, 2'd1, 32'h280100, 32'h0,    32'hA1B2, 8'd3},   // R3
        '{1'b0, 2'd0, 32'h280100, 32'h0,    32'hA1,   8'd3},   // R3 even byte
        '{1'b0, 2'd0, 32'h280101, 32'h0,    32'hB2,   8'd3},   // R3 odd byte
        '{1'b1, 2'd0, 32'h280101, 32'h7C,   32'h0,    8'd5},   // R5 odd byte write
        '{1'b0, 2'd1, 32'h280100, 32'h0,    32'hA17C, 8'd5},   // R5
        '{1'b0, 2'd1, 32'h200010, 32'h0,    32'hA5CB, 8'd3},   // R3 ROM
        '{1'b0, 2'd0, 32'h200011, 32'h0,    32'hCB,   8'd3},   // R3
        '{1'b1, 2'd1, 32'h200010, 32'h0,    32'h0,    8'd5},   // R5 ROM write dropped
        '{1'b0, 2'd1, 32'h200010, 32'h0,    32'hA5CB, 8'd5},   // R5
        '{1'b0, 2'd1, 32'h260000, 32'h0,    32'h0,    8'd4},   // R4 gap
        '{1'b1, 2'd1, 32'h260004, 32'h1111, 32'h0,    8'd5},   // R5 gap write
        '{1'b0, 2'd1, 32'h260004, 32'h0,    32'h0,    8'd4},   // R4
        '{1'b0, 2'd1, 32'h300010, 32'h0,    32'hA5CB, 8'd1},   // R1 alias above
        '{1'b1, 2'd1, 32'h380200, 32'h4242, 32'h0,    8'd1},   // R1
        '{1'b0, 2'd1, 32'h280200, 32'h0,    32'h4242, 8'd1},   // R1
        '{1'b0, 2'd1, 32'h1FFFFE, 32'h0,    32'h5A3C, 8'd1},   // R1 below base
        '{1'b0, 2'd1, 32'h2F0000, 32'h0,    32'h25C3, 8'd2},   // R2 bank F memory
        '{1'b0, 2'd1, 32'h236000, 32'h0,    32'h15C3, 8'd2},   // R2 bank 3 memory
        '{1'b0, 2'd2, 32'h250006, 32'h0,    32'hCAFE0000, 8'd6} // R6 long over regs
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc, wc0;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(host_ack == 1'b0, "R12 reset ack", {31'b0, host_ack}, 32'h0);
        chk(mem_en == 1'b0, "R12 reset mem_en", {31'b0, mem_en}, 32'h0);
        chk(host_rdata == '0, "R12 reset rdata", host_rdata, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd, rd, cyc);
            if (!VEC[i].we)
                chk(rd == VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].rq, i), rd, VEC[i].exp);
        end

        // R12 latency and single pulse
        acc(1'b0, 2'd1, 32'h250006, 32'h0, rd, cyc);
        chk(cyc == 3, "R12 word latency", 32'(cyc), 32'd3);
        @(negedge clk);
        chk(host_ack == 1'b0, "R12 ack one cycle", {31'b0, host_ack}, 32'h0);
        acc(1'b0, 2'd2, 32'h280100, 32'h0, rd, cyc);
        chk(cyc == 5, "R12 long latency", 32'(cyc), 32'd5);

        // R6 long write order
        acc(1'b1, 2'd2, 32'h280400, 32'h11223344, rd, cyc);
        chk(prev_a == 'h40200 && prev_d == 16'h1122, "R6 first half",
            {prev_d, 16'(prev_a)}, 32'h1122_0200);
        chk(last_a == 'h40201 && last_d == 16'h3344, "R6 second half",
            {last_d, 16'(last_a)}, 32'h3344_0201);
        acc(1'b0, 2'd2, 32'h280400, 32'h0, rd, cyc);
        chk(rd == 32'h11223344, "R6 long read", rd, 32'h11223344);

        // R5 dropped writes issue no memory write
        wc0 = wr_cnt;
        acc(1'b1, 2'd1, 32'h200020, 32'hDEAD, rd, cyc);
        acc(1'b1, 2'd0, 32'h260001, 32'h55, rd, cyc);
        chk(wr_cnt == wc0, "R5 no write below RAM", 32'(wr_cnt), 32'(wc0));

        // R10 status and R8 flags
        @(negedge clk); aud_evt_a = 16'h0003;
        @(negedge clk); aud_evt_a = 16'h0000;
        acc(1'b0, 2'd1, 32'h250008, 32'h0, rd, cyc);
        chk(rd == 32'h0003, "R10 status A", rd, 32'h0003);
        acc(1'b0, 2'd1, 32'h240000, 32'h0, rd, cyc);
        chk(rd == 32'h5234, "R8 audio flag", rd, 32'h5234);
        @(negedge clk); aud_evt_b = 16'h8000;
        @(negedge clk); aud_evt_b = 16'h0000;
        acc(1'b0, 2'd1, 32'h25000A, 32'h0, rd, cyc);
        chk(rd == 32'h8000, "R10 status B", rd, 32'h8000);
        acc(1'b0, 2'd1, 32'h250008, 32'h0, rd, cyc);
        chk(rd == 32'h0003, "R10 status sticky", rd, 32'h0003);
        vid_irq = 1'b1;
        acc(1'b0, 2'd1, 32'h240000, 32'h0, rd, cyc);
        chk(rd == 32'hD234, "R8 video flag", rd, 32'hD234);
        acc(1'b1, 2'd1, 32'h250008, 32'h0000, rd, cyc);
        acc(1'b0, 2'd1, 32'h240000, 32'h0, rd, cyc);
        chk(rd == 32'h9234, "R8 masked off", rd, 32'h9234);
        acc(1'b0, 2'd1, 32'h250008, 32'h0, rd, cyc);
        chk(rd == 32'h0003, "R10 mask write keeps status", rd, 32'h0003);

        // R12 reset clears storage
        vid_irq = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        acc(1'b0, 2'd1, 32'h250006, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R12 reset audio reg", rd, 32'h0);
        acc(1'b0, 2'd1, 32'h240000, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R12 reset io word", rd, 32'h0);
        acc(1'b0, 2'd1, 32'h250008, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R12 reset status", rd, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule